// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a synchronous host port and an asynchronous DRAM whose address pins are shared by row and column. A request carries a word address: the upper ten bits select the row and the lower ten bits select the column. The controller drives the row and column strobes, the write strobe, the output enable, the row/column mux select and the 4-bit write data. For reads it captures the 4-bit read data and returns it with a one-cycle valid strobe. Each timing minimum is given in picoseconds and turned into a clock count at elaboration, rounding up from the clock period parameter.

After an access the row stays open. A later request to the same row is served by pulsing only the column strobe. A request to a different row, or a pending refresh, makes the controller close the page and precharge. Refresh requests come from an external scheduler. The controller runs a column-before-row refresh cycle and acknowledges it with a one-cycle grant. Writes use early-write timing: the write strobe falls together with the column strobe and the output enable stays high, so the DRAM never drives the data pins during a write.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is asserted, all four strobes are high (inactive), the data driver enable is low, and the read valid and refresh grant are low. After reset, with no refresh pending, req_ready_o is high.
- R2: Row bits [19:10] are on dram_addr_o with dram_col_sel_o low when the row strobe falls. Column bits [9:0] are on dram_addr_o, and dram_col_sel_o has already been high for a cycle, when the column strobe falls.
- R3: The row strobe stays low for at least RAS_C cycles. It then stays high for at least PRE_C = max(RP_C, RC_C-RAS_C) cycles, so that consecutive row-strobe falls are at least RC_C cycles apart.
- R4: The mux switches to the column at least RAH_C cycles after the row strobe falls. The first column strobe of a row falls at least max(RCD_C, RAH_C+1) cycles after the row strobe falls.
- R5: Every column strobe is low for at least CASLO_C = max(CAS, CAC, CAH, DH counts) cycles. Within one open row it is high for at least max(CP_C, PC_C-CASLO_C) cycles between pulses, and its falling edges are at least PC_C cycles apart.
- R6: Read data is sampled on the last low cycle of the column strobe. This is no earlier than CAC_C cycles after the column strobe falls and RAC_C cycles after the row strobe falls. The data is presented on rd_data_o with rd_valid_o high for exactly one cycle.
- R7: For a write, the write strobe (active low) falls on the same edge as the column strobe, dram_dq_oe_o is high and the output enable is high. Both are released when the column strobe rises. The DRAM receives the requested column and data.
- R8: A request to the currently open row is accepted without a new row-strobe fall.
- R9: A request to a different row is held off with req_ready_o low until the page has been closed and precharged, and it then causes exactly one new row-strobe fall.
- R10: ref_req_i has priority: while it is high, req_ready_o is low. The open page is closed, then the column strobe falls at least CSR_C cycles before the row strobe, with the write strobe high. ref_gnt_o pulses for one cycle on the edge where the row strobe rises at the end of the refresh. The next access reopens a row.
- R11: With the default 8000 ps clock, the cycle counts are RAS_C=7, PRE_C=5, RC_C=12, RAH_C=1, first-CAS delay 3, CASLO_C=2, column high 3, PC_C=5, RAC_C=7, CAC_C=2 and CSR_C=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Request accepted on this cycle when valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 20 | Word address, row in [19:10], column in [9:0] |
| req_wdata_i | input | 4 | Write data |
| rd_valid_o | output | 1 | One-cycle read data strobe |
| rd_data_o | output | 4 | Read result |
| ref_req_i | input | 1 | Refresh request from the scheduler |
| ref_gnt_o | output | 1 | One-cycle refresh completion grant |
| dram_ras_n_o | output | 1 | Row strobe, active low |
| dram_cas_n_o | output | 1 | Column strobe, active low |
| dram_we_n_o | output | 1 | Write strobe, active low |
| dram_oe_n_o | output | 1 | Output enable, active low |
| dram_col_sel_o | output | 1 | Address mux select, 1 = column |
| dram_addr_o | output | 10 | Multiplexed DRAM address |
| dram_dq_o | output | 4 | Write data to DRAM |
| dram_dq_oe_o | output | 1 | Enable for the data pin drivers |
| dram_dq_i | input | 4 | Read data from DRAM |

## Verification
The assertions assume that the host keeps a request stable from the cycle valid rises until it is accepted. They also assume that the scheduler lowers ref_req_i within a few cycles of the grant, before the precharge that follows the refresh ends, so that a single request is not counted as two refreshes. The bench drives its inputs on falling edges and holds each request until it sees ready. It drops the refresh request on the cycle after the grant. Its DRAM model returns data only while the column strobe is low. It stores the data it captures at write column strobes, so reads of written words return that data and reads of other words return an address hash.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ROW, S_COL, S_CASH, S_OPEN, S_PRE, S_RCAS, S_RRAS
  } fpm_state_e;

  function automatic int unsigned ps2cyc(input int unsigned ps, input int unsigned clk_ps);
    int unsigned c;
    c = (ps + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/fpm_elapsed.sv
module fpm_elapsed #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_o <= '0;
    else if (clr_i)        cnt_o <= '0;
    else if (cnt_o != '1)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/fpm_row_track.sv
module fpm_row_track #(
  parameter int unsigned ROW_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic             close_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [ROW_W-1:0] cmp_row_i,
  output logic             hit_o
);
  logic [ROW_W-1:0] row_q;
  logic             vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      vld_q <= 1'b0;
    end else if (open_i) begin
      row_q <= row_i;
      vld_q <= 1'b1;
    end else if (close_i) begin
      vld_q <= 1'b0;
    end
  end

  assign hit_o = vld_q && (cmp_row_i == row_q);
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int unsigned ROW_W     = 10,
  parameter int unsigned COL_W     = 10,
  parameter int unsigned DQ_W      = 4,
  parameter int unsigned CLK_PS    = 8000,
  parameter int unsigned T_RAS_PS  = 50000,
  parameter int unsigned T_RP_PS   = 35000,
  parameter int unsigned T_RC_PS   = 95000,
  parameter int unsigned T_RCD_PS  = 18000,
  parameter int unsigned T_RAH_PS  = 8000,
  parameter int unsigned T_CAS_PS  = 13000,
  parameter int unsigned T_CP_PS   = 10000,
  parameter int unsigned T_PC_PS   = 35000,
  parameter int unsigned T_CAH_PS  = 10000,
  parameter int unsigned T_DH_PS   = 10000,
  parameter int unsigned T_CAC_PS  = 13000,
  parameter int unsigned T_RAC_PS  = 50000,
  parameter int unsigned T_CSR_PS  = 10000,
  parameter int unsigned T_CHR_PS  = 10000,
  localparam int unsigned ADDR_W   = ROW_W + COL_W,
  localparam int unsigned DA_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DQ_W-1:0]   req_wdata_i,
  output logic              rd_valid_o,
  output logic [DQ_W-1:0]   rd_data_o,
  input  logic              ref_req_i,
  output logic              ref_gnt_o,
  output logic              dram_ras_n_o,
  output logic              dram_cas_n_o,
  output logic              dram_we_n_o,
  output logic              dram_oe_n_o,
  output logic              dram_col_sel_o,
  output logic [DA_W-1:0]   dram_addr_o,
  output logic [DQ_W-1:0]   dram_dq_o,
  output logic              dram_dq_oe_o,
  input  logic [DQ_W-1:0]   dram_dq_i
);
  localparam int unsigned RAS_C   = ps2cyc(T_RAS_PS, CLK_PS);
  localparam int unsigned RP_C    = ps2cyc(T_RP_PS, CLK_PS);
  localparam int unsigned RC_C    = ps2cyc(T_RC_PS, CLK_PS);
  localparam int unsigned RAH_C   = ps2cyc(T_RAH_PS, CLK_PS);
  localparam int unsigned RCDX_C  = umax(ps2cyc(T_RCD_PS, CLK_PS), RAH_C + 1);
  localparam int unsigned CAC_C   = ps2cyc(T_CAC_PS, CLK_PS);
  localparam int unsigned RAC_C   = ps2cyc(T_RAC_PS, CLK_PS);
  localparam int unsigned CASLO_C = umax(umax(ps2cyc(T_CAS_PS, CLK_PS), CAC_C),
                                         umax(ps2cyc(T_CAH_PS, CLK_PS), ps2cyc(T_DH_PS, CLK_PS)));
  localparam int unsigned PC_C    = ps2cyc(T_PC_PS, CLK_PS);
  localparam int unsigned CPH_C   = umax(ps2cyc(T_CP_PS, CLK_PS),
                                         (PC_C > CASLO_C) ? PC_C - CASLO_C : 1);
  localparam int unsigned PRE_C   = umax(RP_C, (RC_C > RAS_C) ? RC_C - RAS_C : 1);
  localparam int unsigned CSR_C   = ps2cyc(T_CSR_PS, CLK_PS);
  localparam int unsigned RLOW_C  = umax(RAS_C, ps2cyc(T_CHR_PS, CLK_PS));
  localparam int unsigned TMAX    = umax(umax(umax(RLOW_C, RAC_C), umax(PRE_C, CPH_C)),
                                         umax(umax(RCDX_C, CASLO_C), CSR_C));
  localparam int unsigned TW      = $clog2(TMAX + 2);

  // limit L means "L cycles elapsed at this edge": counter reads L-1
  localparam logic [TW-1:0] L_RAS   = TW'(RAS_C - 1);
  localparam logic [TW-1:0] L_RAH   = TW'(RAH_C - 1);
  localparam logic [TW-1:0] L_RCDX  = TW'(RCDX_C - 1);
  localparam logic [TW-1:0] L_RAC   = TW'(RAC_C - 1);
  localparam logic [TW-1:0] L_CASLO = TW'(CASLO_C - 1);
  localparam logic [TW-1:0] L_CPH   = TW'(CPH_C - 1);
  localparam logic [TW-1:0] L_PRE   = TW'(PRE_C - 1);
  localparam logic [TW-1:0] L_CSR   = TW'(CSR_C - 1);
  localparam logic [TW-1:0] L_RLOW  = TW'(RLOW_C - 1);

  fpm_state_e        state_q, state_d;
  logic [TW-1:0]     tmr_q, ras_age_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q, wr_d;
  logic              acc, smp, gnt_d, hit;
  logic              ras_n_d, cas_n_d, we_n_d, oe_n_d, col_sel_d;

  fpm_elapsed #(.W(TW)) u_state_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (state_d != state_q),
    .cnt_o (tmr_q)
  );

  fpm_elapsed #(.W(TW)) u_ras_age (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (dram_ras_n_o && !ras_n_d),
    .cnt_o (ras_age_q)
  );

  fpm_row_track #(.ROW_W(ROW_W)) u_row (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .open_i   (acc && (state_q == S_IDLE)),
    .close_i  ((state_d == S_PRE) && (state_q != S_PRE)),
    .row_i    (req_addr_i[ADDR_W-1:COL_W]),
    .cmp_row_i(req_addr_i[ADDR_W-1:COL_W]),
    .hit_o    (hit)
  );

  assign req_ready_o = !ref_req_i && ((state_q == S_IDLE) || ((state_q == S_OPEN) && hit));

  always_comb begin
    state_d = state_q;
    acc     = 1'b0;
    smp     = 1'b0;
    gnt_d   = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (ref_req_i) state_d = S_RCAS;
        else if (req_valid_i) begin
          state_d = S_ROW;
          acc     = 1'b1;
        end
      end
      S_ROW:  if (tmr_q >= L_RCDX) state_d = S_COL;
      S_COL: begin
        if ((tmr_q >= L_CASLO) && (wr_q || (ras_age_q >= L_RAC))) begin
          state_d = S_CASH;
          smp     = !wr_q;
        end
      end
      S_CASH: if (tmr_q >= L_CPH) state_d = S_OPEN;
      S_OPEN: begin
        if (ref_req_i || (req_valid_i && !hit)) begin
          if (ras_age_q >= L_RAS) state_d = S_PRE;
        end else if (req_valid_i) begin
          state_d = S_COL;
          acc     = 1'b1;
        end
      end
      S_PRE:  if (tmr_q >= L_PRE) state_d = S_IDLE;
      S_RCAS: if (tmr_q >= L_CSR) state_d = S_RRAS;
      S_RRAS: begin
        if (ras_age_q >= L_RLOW) begin
          state_d = S_PRE;
          gnt_d   = 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    wr_d      = acc ? req_we_i : wr_q;
    ras_n_d   = !(state_d inside {S_ROW, S_COL, S_CASH, S_OPEN, S_RRAS});
    cas_n_d   = !(state_d inside {S_COL, S_RCAS, S_RRAS});
    we_n_d    = !((state_d == S_COL) && wr_d);
    oe_n_d    = !((state_d == S_COL) && !wr_d);
    col_sel_d = ((state_q == S_ROW) && (state_d == S_ROW) && (tmr_q >= L_RAH)) ||
                (state_d inside {S_COL, S_CASH, S_OPEN});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= S_IDLE;
      addr_q         <= '0;
      wr_q           <= 1'b0;
      dram_dq_o      <= '0;
      dram_ras_n_o   <= 1'b1;
      dram_cas_n_o   <= 1'b1;
      dram_we_n_o    <= 1'b1;
      dram_oe_n_o    <= 1'b1;
      dram_dq_oe_o   <= 1'b0;
      dram_col_sel_o <= 1'b0;
      rd_valid_o     <= 1'b0;
      rd_data_o      <= '0;
      ref_gnt_o      <= 1'b0;
    end else begin
      state_q        <= state_d;
      wr_q           <= wr_d;
      if (acc) begin
        addr_q    <= req_addr_i;
        dram_dq_o <= req_wdata_i;
      end
      dram_ras_n_o   <= ras_n_d;
      dram_cas_n_o   <= cas_n_d;
      dram_we_n_o    <= we_n_d;
      dram_oe_n_o    <= oe_n_d;
      dram_dq_oe_o   <= !we_n_d;
      dram_col_sel_o <= col_sel_d;
      rd_valid_o     <= smp;
      if (smp) rd_data_o <= dram_dq_i;
      ref_gnt_o      <= gnt_d;
    end
  end

  assign dram_addr_o = dram_col_sel_o ? DA_W'(addr_q[COL_W-1:0])
                                      : DA_W'(addr_q[ADDR_W-1:COL_W]);
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
  parameter int unsigned RAS_C = 7,
  parameter int unsigned PRE_C = 5,
  parameter int unsigned PC_C  = 5
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ras_n_i,
  input logic cas_n_i,
  input logic we_n_i,
  input logic oe_n_i,
  input logic dq_oe_i,
  input logic col_sel_i,
  input logic rd_valid_i,
  input logic ref_gnt_i
);
  logic [15:0] ras_lo_q, ras_hi_q, cas_ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_lo_q <= '0;
      ras_hi_q <= '1;
      cas_ff_q <= '1;
    end else begin
      ras_lo_q <= ras_n_i ? '0 : ((ras_lo_q == '1) ? ras_lo_q : ras_lo_q + 1'b1);
      ras_hi_q <= !ras_n_i ? '0 : ((ras_hi_q == '1) ? ras_hi_q : ras_hi_q + 1'b1);
      cas_ff_q <= (!cas_n_i && $past(cas_n_i)) ? 16'd1
                  : ((cas_ff_q == '1) ? cas_ff_q : cas_ff_q + 1'b1);
    end
  end

  a_r3_ras_low_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_i) |-> (ras_lo_q >= 16'(RAS_C)));
  a_r3_precharge_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_i) |-> (ras_hi_q >= 16'(PRE_C)));
  a_r2_col_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cas_n_i) && !ras_n_i) |-> $past(col_sel_i));
  a_r5_cas_pitch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_n_i) |-> (cas_ff_q >= 16'(PC_C)));
  a_r7_early_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_n_i) |-> $fell(cas_n_i));
  a_r7_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_i |-> oe_n_i);
  a_r6_rd_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> !rd_valid_i);
  a_r10_gnt_at_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_gnt_i |-> $rose(ras_n_i));
  a_r10_cas_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_i) && !cas_n_i) |-> !$past(cas_n_i));
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(
  .RAS_C(RAS_C), .PRE_C(PRE_C), .PC_C(PC_C)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ras_n_i   (dram_ras_n_o),
  .cas_n_i   (dram_cas_n_o),
  .we_n_i    (dram_we_n_o),
  .oe_n_i    (dram_oe_n_o),
  .dq_oe_i   (dram_dq_oe_o),
  .col_sel_i (dram_col_sel_o),
  .rd_valid_i(rd_valid_o),
  .ref_gnt_i (ref_gnt_o)
);

// File: tb/fpm_dram_ctrl_bench.sv
module fpm_dram_ctrl_bench;
  // expected cycle counts at 8000 ps (R11)
  localparam int E_RAS = 7, E_PRE = 5, E_RC = 12, E_RCDX = 3, E_CASLO = 2;
  localparam int E_CPH = 3, E_PC = 5, E_RAC = 7, E_CAC = 2, E_CSR = 2;
  localparam int NV = 11;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 20'h0A005, 4'h3}, {1'b1, 20'h0A006, 4'hC}, {1'b0, 20'h0A005, 4'h0},
    {1'b0, 20'h0A3FF, 4'h0}, {1'b0, 20'h15000, 4'h0}, {1'b1, 20'h15001, 4'h9},
    {1'b0, 20'h15001, 4'h0}, {1'b0, 20'h0A006, 4'h0}, {1'b1, 20'hFFFFF, 4'hF},
    {1'b0, 20'hFFFFF, 4'h0}, {1'b0, 20'h00000, 4'h0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, ref_req = 1'b0;
  logic [19:0] req_addr = '0;
  logic [3:0]  req_wdata = '0, rd_model = '0;
  logic req_ready, rd_valid, ref_gnt, ras_n, cas_n, we_n, oe_n, col_sel, dq_oe;
  logic [3:0] rd_data, dq_o;
  logic [9:0] dram_addr;

  int checks = 0, errors = 0, cyc = 0;
  logic [3:0] mem [int];
  logic [3:0] exp_mem [int];

  always #4 clk = ~clk;

  fpm_dram_ctrl u_fpm_dram_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .ref_req_i(ref_req), .ref_gnt_o(ref_gnt),
    .dram_ras_n_o(ras_n), .dram_cas_n_o(cas_n), .dram_we_n_o(we_n), .dram_oe_n_o(oe_n),
    .dram_col_sel_o(col_sel), .dram_addr_o(dram_addr),
    .dram_dq_o(dq_o), .dram_dq_oe_o(dq_oe), .dram_dq_i(rd_model)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] hash(input logic [19:0] a);
    return a[3:0] ^ a[13:10] ^ 4'h6;
  endfunction

  // DRAM model and timing monitor, sampled on falling edges
  logic pr_ras = 1, pr_cas = 1, pr_we = 1, pr_csel = 0, pr_rdv = 0;
  int t_rfall = 0, t_rrise = 0, t_cfall = 0, t_crise = 0;
  bit have_rise = 0, page_crise = 0;
  int n_acc = 0, n_ref = 0, n_wr = 0;
  logic [9:0] m_row = '0, m_col = '0, w_row = '0, w_col = '0;
  logic [3:0] w_dat = '0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      pr_ras = 1; pr_cas = 1; pr_we = 1; pr_csel = 0; pr_rdv = 0;
    end else begin
      if (pr_ras && !ras_n) begin
        if (have_rise) begin
          chk(cyc - t_rrise >= E_PRE, "R3 precharge", cyc - t_rrise, E_PRE);
          chk(cyc - t_rfall >= E_RC, "R3 row cycle", cyc - t_rfall, E_RC);
        end
        if (cas_n) begin
          n_acc++;
          m_row = dram_addr;
          chk(!col_sel, "R2 row phase select", col_sel, 0);
        end else begin
          n_ref++;
          chk(cyc - t_cfall >= E_CSR, "R10 cas lead", cyc - t_cfall, E_CSR);
          chk(we_n, "R10 we high in refresh", we_n, 1);
        end
        t_rfall = cyc; page_crise = 0;
      end
      if (!pr_ras && ras_n) begin
        chk(cyc - t_rfall >= E_RAS, "R3 ras low", cyc - t_rfall, E_RAS);
        t_rrise = cyc; have_rise = 1; page_crise = 0;
      end
      if (pr_cas && !cas_n) begin
        if (!ras_n) begin
          chk(pr_csel, "R2 column setup", pr_csel, 1);
          m_col = dram_addr;
          if (page_crise) begin
            chk(cyc - t_crise >= E_CPH, "R5 cas high", cyc - t_crise, E_CPH);
            chk(cyc - t_cfall >= E_PC, "R5 page pitch", cyc - t_cfall, E_PC);
          end else begin
            chk(cyc - t_rfall >= E_RCDX, "R4 ras to cas", cyc - t_rfall, E_RCDX);
          end
          rd_model = mem.exists(int'({m_row, m_col})) ? mem[int'({m_row, m_col})]
                                                       : hash({m_row, m_col});
          if (!we_n) begin
            chk(dq_oe && oe_n, "R7 pins released by dram", {dq_oe, oe_n}, 2'b11);
            w_row = m_row; w_col = m_col; w_dat = dq_o;
            mem[int'({m_row, m_col})] = dq_o;
            n_wr++;
          end
        end
        t_cfall = cyc;
      end
      if (!pr_cas && cas_n) begin
        chk(cyc - t_cfall >= E_CASLO, "R5 cas low", cyc - t_cfall, E_CASLO);
        if (!pr_we) chk(we_n && !dq_oe, "R7 write release", {we_n, dq_oe}, 2'b10);
        if (!ras_n) page_crise = 1;
        t_crise = cyc;
      end
      if (rd_valid && !pr_rdv) begin
        chk(cyc - t_rfall >= E_RAC, "R6 row access", cyc - t_rfall, E_RAC);
        chk(cyc - t_cfall >= E_CAC, "R6 column access", cyc - t_cfall, E_CAC);
      end
      pr_ras = ras_n; pr_cas = cas_n; pr_we = we_n; pr_csel = col_sel; pr_rdv = rd_valid;
    end
  end

  bit page_open = 0;
  logic [9:0] open_row = '0;

  task automatic do_req(input logic we, input logic [19:0] a, input logic [3:0] d);
    int f0, w0;
    bit miss;
    logic [3:0] e;
    f0 = n_acc; w0 = n_wr;
    miss = !page_open || (a[19:10] != open_row);
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    for (int k = 0; k < 200 && !req_ready; k++) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    if (we) begin
      for (int k = 0; k < 200 && n_wr == w0; k++) @(negedge clk);
      chk(w_row == a[19:10] && w_col == a[9:0] && w_dat == d, "R7 write word",
          {w_row, w_col, w_dat}, {a, d});
      exp_mem[int'(a)] = d;
    end else begin
      e = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : hash(a);
      for (int k = 0; k < 200 && !rd_valid; k++) @(negedge clk);
      chk(rd_valid && rd_data == e, "R6 read data", {rd_valid, rd_data}, {1'b1, e});
      @(negedge clk);
      chk(!rd_valid, "R6 single strobe", rd_valid, 0);
    end
    chk((n_acc - f0) == (miss ? 1 : 0), miss ? "R9 miss reopens row" : "R8 hit keeps row",
        n_acc - f0, miss ? 1 : 0);
    page_open = 1; open_row = a[19:10];
  endtask

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    chk({ras_n, cas_n, we_n, oe_n, dq_oe, rd_valid, ref_gnt} == 7'b1111000, "R1 reset outputs",
        {ras_n, cas_n, we_n, oe_n, dq_oe, rd_valid, ref_gnt}, 7'b1111000);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && ras_n, "R1 ready after reset", {req_ready, ras_n}, 2'b11);

    for (int i = 0; i < NV; i++) do_req(VEC[i][24], VEC[i][23:4], VEC[i][3:0]);

    // refresh takes priority over a pending hit while the page is open
    r0 = n_ref;
    @(negedge clk);
    ref_req = 1; req_valid = 1; req_we = 0; req_addr = {open_row, 10'h001};
    #1;
    chk(!req_ready, "R10 refresh blocks ready", req_ready, 0);
    for (int k = 0; k < 200 && !ref_gnt; k++) begin
      @(negedge clk);
      if (!ref_gnt) chk(!req_ready, "R10 ready held low", req_ready, 0);
    end
    chk(ref_gnt && ras_n, "R10 grant with row close", {ref_gnt, ras_n}, 2'b11);
    @(negedge clk);
    chk(!ref_gnt, "R10 grant one cycle", ref_gnt, 0);
    ref_req = 0; req_valid = 0;
    chk(n_ref - r0 == 1, "R10 one refresh cycle", n_ref - r0, 1);
    page_open = 0;
    do_req(1'b0, {open_row, 10'h001}, 4'h0);
    do_req(1'b1, {open_row, 10'h3FE}, 4'h5);
    do_req(1'b0, {open_row, 10'h3FE}, 4'h0);

    // refresh from idle page right after a closing miss
    do_req(1'b0, 20'h003FF, 4'h0);
    do_req(1'b0, 20'h00400, 4'h0);
    r0 = n_ref;
    @(negedge clk);
    ref_req = 1;
    for (int k = 0; k < 200 && !ref_gnt; k++) @(negedge clk);
    @(negedge clk);
    ref_req = 0;
    chk(n_ref - r0 == 1, "R10 second refresh", n_ref - r0, 1);
    page_open = 0;
    do_req(1'b0, 20'h00400, 4'h0);

    repeat (20) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule